// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

This block turns characters into asynchronous serial frames on a single output line that rests high. Each frame is a low start bit, then 8 data bits sent least significant bit first, an optional ninth data bit, an optional parity bit, and a high stop bit. A one-deep holding register sits in front of the shift engine. Software can therefore load the next character while the current one is still on the line, and back-to-back frames leave no idle gap between them.

The block advances by one bit for each pulse on `bit_tick`, which comes from a baud generator outside this block. It reports two status flags. `hold_empty` shows that the holding register can take a write. `tx_done` shows that the line carries nothing at all, break characters included. A level-sensitive break request holds the line low for whole character times. One masked interrupt request combines the two flags. When the transmitter enable is low, the block is held quiet.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A frame is a 0 start bit, the data bits with bit 0 first, and a 1 stop bit. `txd` changes only on a clock edge where `bit_tick` is 1, one bit per tick.
- R3: With `nine_bit`=1, the level of `wr_ext` at the time of the write is sent as a ninth data bit, directly after data bit 7.
- R4: With `par_en`=1, a parity bit is sent just before the stop bit. With `par_odd`=0, the data bits plus the parity bit contain an even number of ones. With `par_odd`=1, they contain an odd number of ones.
- R5: A write while `hold_empty`=1 clears `hold_empty` in the next cycle. A write while `hold_empty`=0 is ignored, and the character already held is the one sent.
- R6: When the line is idle and a character is held, the tick loads it. In the next cycle `txd` is 0, `hold_empty` is 1 and `tx_done` is 0.
- R7: If a character is held when the tick that ends a stop bit arrives, that tick starts the new start bit, with no idle bit between the frames.
- R8: If nothing is held and no break is requested when a stop bit ends, `tx_done` and `txd` are 1 in the next cycle.
- R9: When `brk_req` is 1 at the tick where the line becomes free, `txd` is held at 0 for one character time. A character time is 10 + `nine_bit` + `par_en` ticks. The break repeats for as long as `brk_req` is still 1 at the end of each break character, and `tx_done` stays 0 throughout.
- R10: After the last break character, `txd` is 1 for one tick period with `tx_done` still 0, before a held frame starts or the line goes idle. A pending break takes priority over a held character.
- R11: While `tx_en` is 0, writes are ignored and any frame in progress is dropped. From the next cycle on, `txd`, `hold_empty` and `tx_done` are all 1.
- R12: `irq` equals (`irq_empty_en` AND `hold_empty`) OR (`irq_done_en` AND `tx_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Low data bits of the character |
| wr_ext | input | 1 | Ninth data bit, captured when the character is written |
| nine_bit | input | 1 | Enables the ninth data bit |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| brk_req | input | 1 | Send-break request |
| irq_empty_en | input | 1 | Interrupt mask for hold_empty |
| irq_done_en | input | 1 | Interrupt mask for tx_done |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | No frame, break or gap in progress |
| irq | output | 1 | Masked interrupt request |

## Verification
A write shows on `hold_empty` one cycle after its strobe. Each tick shows on `txd`, and on the flags when a frame or break starts or ends, one cycle after the edge where the tick is sampled. `irq` follows the flags in the same cycle. The bench drives every input on the falling clock edge and holds a tick for exactly one cycle. It samples one falling edge later, which is exactly one register stage after the tick. It then waits two idle cycles, so that a wrong output that changes without a tick also shows up. Line levels are compared bit by bit against a frame that the bench builds itself from the mode inputs.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_BRK  = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wext,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] rdata,
  output logic              rext
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr && !full) begin
      full  <= 1'b1;
      rdata <= wdata;
      rext  <= wext;
    end
  end

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !take && !flush) |=> (full && $stable(rdata) && $stable(rext)));
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 4,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] data,
  input  logic              ext,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     nbits
);
  logic par;

  always_comb begin
    par = (^data) ^ (nine & ext) ^ par_odd;
    unique case ({nine, par_en})
      2'b00:   frame = {3'b111, data, 1'b0};
      2'b01:   frame = {2'b11, par, data, 1'b0};
      2'b10:   frame = {2'b11, ext, data, 1'b0};
      default: frame = {1'b1, par, ext, data, 1'b0};
    endcase
    nbits = CW'(DATA_W + 2) + CW'(nine) + CW'(par_en);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 4,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          brk,
  input  logic          hold_full,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  output logic          take,
  output logic          txd,
  output logic          done
);
  tx_state_t     state;
  logic [CW-1:0] cnt;
  logic [FW-1:0] shreg;
  logic          free;

  always_comb begin
    free = 1'b0;
    if (en && tick) begin
      unique case (state)
        ST_IDLE:        free = 1'b1;
        ST_DATA, ST_GAP: free = (cnt == '0);
        default:        free = 1'b0;
      endcase
    end
    take = free && !brk && hold_full;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      txd   <= 1'b1;
      done  <= 1'b1;
      cnt   <= '0;
      shreg <= '1;
    end else if (tick) begin
      if (free) begin
        if (brk) begin
          state <= ST_BRK;
          txd   <= 1'b0;
          done  <= 1'b0;
          cnt   <= nbits - CW'(1);
        end else if (hold_full) begin
          state <= ST_DATA;
          txd   <= frame[0];
          shreg <= {1'b1, frame[FW-1:1]};
          done  <= 1'b0;
          cnt   <= nbits - CW'(1);
        end else begin
          state <= ST_IDLE;
          txd   <= 1'b1;
          done  <= 1'b1;
        end
      end else if (state == ST_BRK && cnt == '0) begin
        if (brk) begin
          cnt <= nbits - CW'(1);
        end else begin
          state <= ST_GAP;
          txd   <= 1'b1;
        end
      end else if (state == ST_DATA) begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[FW-1:1]};
        cnt   <= cnt - CW'(1);
      end else if (state == ST_BRK) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (txd && done));
  // R2
  txd_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(txd));
  // R6
  start_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!txd && !done));
  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BRK) |-> (!txd && !done));
  // R10
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (txd && !done));
  // R11
  off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (txd && done && state == ST_IDLE));
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ext,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              brk_req,
  input  logic              irq_empty_en,
  input  logic              irq_done_en,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq
);
  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  logic              hold_full, take, h_ext;
  logic [DATA_W-1:0] h_data;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     nbits;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .flush(!tx_en), .wr(wr_en && tx_en),
    .wdata(wr_data), .wext(wr_ext), .take(take),
    .full(hold_full), .rdata(h_data), .rext(h_ext)
  );

  sertx_frame #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_frame (
    .nine(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .data(h_data), .ext(h_ext), .frame(frame), .nbits(nbits)
  );

  sertx_shift #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .en(tx_en), .tick(bit_tick), .brk(brk_req),
    .hold_full(hold_full), .frame(frame), .nbits(nbits),
    .take(take), .txd(txd), .done(tx_done)
  );

  assign hold_empty = !hold_full;
  assign irq = (irq_empty_en && hold_empty) || (irq_done_en && tx_done);

  // R5
  wr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_en && hold_empty) |=> !hold_empty);
endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb;
  logic clk = 0, rst = 1, tx_en = 0, bit_tick = 0, wr_en = 0, wr_ext = 0;
  logic nine_bit = 0, par_en = 0, par_odd = 0, brk_req = 0;
  logic irq_empty_en = 0, irq_done_en = 0;
  logic [7:0] wr_data = 0;
  logic txd, hold_empty, tx_done, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sertx_core u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_ext(wr_ext), .nine_bit(nine_bit), .par_en(par_en),
    .par_odd(par_odd), .brk_req(brk_req), .irq_empty_en(irq_empty_en),
    .irq_done_en(irq_done_en), .txd(txd), .hold_empty(hold_empty),
    .tx_done(tx_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
  endtask

  task automatic pad();
    repeat (2) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d, input logic e);
    @(negedge clk) begin wr_en = 1; wr_data = d; wr_ext = e; end
    @(negedge clk) begin wr_en = 0; wr_ext = ~e; end
  endtask

  function automatic logic [15:0] build(input logic [7:0] d, input logic e,
                                        input logic nine, input logic par, input logic odd);
    logic [15:0] b = '1;
    int idx = 0;
    int ones = $countones(d) + ((nine && e) ? 1 : 0);
    b[idx] = 1'b0; idx++;
    for (int i = 0; i < 8; i++) begin b[idx] = d[i]; idx++; end
    if (nine) begin b[idx] = e; idx++; end
    if (par) begin b[idx] = odd ? ~ones[0] : ones[0]; idx++; end
    b[idx] = 1'b1;
    return b;
  endfunction

  // shift out bits from..n-1 of an expected frame
  task automatic run_bits(input logic [15:0] b, input int from, input int n, input string req);
    for (int k = from; k < n; k++) begin
      do_tick();
      check(req, txd, b[k]);
      pad();
      check({req, " between ticks (R2)"}, txd, b[k]);
    end
  endtask

  task automatic t_reset();
    check("R1 txd", txd, 1);
    check("R1 hold_empty", hold_empty, 1);
    check("R1 tx_done", tx_done, 1);
    check("R12 irq masked", irq, 0);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic e, input logic nine,
                         input logic par, input logic odd, input string req);
    logic [15:0] b = build(d, e, nine, par, odd);
    int n = 10 + nine + par;
    nine_bit = nine; par_en = par; par_odd = odd;
    write(d, e);
    check("R5 hold_empty after write", hold_empty, 0);
    do_tick();
    check("R6 start bit", txd, 0);
    check("R6 hold_empty", hold_empty, 1);
    check("R6 tx_done", tx_done, 0);
    pad();
    run_bits(b, 1, n, req);
    do_tick();
    check("R8 tx_done", tx_done, 1);
    check("R8 txd", txd, 1);
    pad();
  endtask

  task automatic t_back_to_back();
    logic [15:0] a = build(8'h3C, 0, 0, 0, 0);
    logic [15:0] c = build(8'hC1, 0, 0, 0, 0);
    nine_bit = 0; par_en = 0;
    write(8'h3C, 0);
    do_tick();
    write(8'hC1, 0);
    check("R5 second held", hold_empty, 0);
    run_bits(a, 1, 10, "R7 first frame");
    do_tick();
    check("R7 no gap start", txd, 0);
    check("R7 tx_done", tx_done, 0);
    check("R7 hold taken", hold_empty, 1);
    run_bits(c, 1, 10, "R7 second frame");
    do_tick();
    check("R8 idle", tx_done, 1);
  endtask

  task automatic t_overwrite();
    logic [15:0] a = build(8'h81, 0, 0, 0, 0);
    write(8'h81, 0);
    write(8'h7E, 0);
    check("R5 still full", hold_empty, 0);
    do_tick();
    check("R5 start", txd, 0);
    run_bits(a, 1, 10, "R5 first char kept");
    do_tick();
  endtask

  task automatic t_break();
    logic [15:0] c = build(8'h55, 0, 0, 0, 0);
    nine_bit = 0; par_en = 0;
    @(negedge clk) brk_req = 1;
    do_tick();
    check("R9 low", txd, 0);
    check("R9 done low", tx_done, 0);
    write(8'h55, 0);
    for (int k = 1; k < 20; k++) begin
      if (k == 15) brk_req = 0;
      do_tick();
      check("R9 held low", txd, 0);
      check("R9 done low", tx_done, 0);
    end
    do_tick();
    check("R10 gap high", txd, 1);
    check("R10 gap not done", tx_done, 0);
    check("R10 char waits", hold_empty, 0);
    do_tick();
    check("R10 frame after gap", txd, 0);
    check("R10 hold taken", hold_empty, 1);
    run_bits(c, 1, 10, "R10 frame");
    do_tick();
    check("R8 idle", tx_done, 1);
  endtask

  task automatic t_disable();
    @(negedge clk) tx_en = 0;
    write(8'h12, 0);
    check("R11 write ignored", hold_empty, 1);
    @(negedge clk) brk_req = 1;
    do_tick();
    check("R11 no break", txd, 1);
    check("R11 done", tx_done, 1);
    @(negedge clk) begin brk_req = 0; tx_en = 1; end
    write(8'h00, 0);
    do_tick();
    do_tick();
    check("R11 mid frame low", txd, 0);
    @(negedge clk) tx_en = 0;
    @(negedge clk) tx_en = 1;
    check("R11 abort txd", txd, 1);
    check("R11 abort done", tx_done, 1);
    check("R11 abort empty", hold_empty, 1);
    do_tick();
    check("R11 stays idle", txd, 1);
  endtask

  task automatic t_irq();
    @(negedge clk) irq_empty_en = 1;
    #1 check("R12 empty irq", irq, 1);
    write(8'hF0, 0);
    check("R12 full masks", irq, 0);
    @(negedge clk) irq_done_en = 1;
    #1 check("R12 done irq", irq, 1);
    @(negedge clk) irq_empty_en = 0;
    do_tick();
    check("R12 busy no irq", irq, 0);
    for (int k = 1; k < 11; k++) do_tick();
    check("R12 done again", irq, 1);
    @(negedge clk) irq_done_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    tx_en = 1;
    t_frame(8'hA5, 0, 0, 0, 0, "R2 8N1");
    t_frame(8'h0F, 1, 1, 0, 0, "R3 nine bit");
    t_frame(8'h07, 0, 0, 1, 0, "R4 even parity");
    t_frame(8'h07, 1, 1, 1, 1, "R4 odd parity");
    t_back_to_back();
    t_overwrite();
    t_break();
    t_disable();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule